// File: doc/BRIEF.md
# Partitioned Tagged Byte FIFO with Freeze Mode

This block holds one byte buffer of `DEPTH` entries (128 by default) and splits it, at a programmable boundary, into two queues. The input queue is filled by a host and drained by a local CPU. The output queue is filled by the local CPU and drained by the host. Every stored byte carries one tag bit that marks it as a plain data byte or as a stream command byte. The local CPU reads data and command bytes through two separate registers. A read through the register that does not match the head byte's tag returns 0xFF. Active-low service-request flags tell the CPU when each queue needs attention.

A freeze mode stops all host traffic into and out of the queues. It also lets the CPU load the read and write pointers directly. When the two pointers are loaded to the same value, the order of the loads decides whether the queue counts as full or as empty. The CPU can therefore reach every byte of a partition. A pair of one-byte immediate command registers gives the host a side channel. In freeze mode, host access to these registers is refused.

Top module: `tf_part_fifo`

## Requirements
- R1: The input partition holds B+1 bytes and the output partition holds the rest of the buffer, where B is the boundary value (CPU register 8, bits 6:0). A boundary of 0 gives the input partition 0 bytes and the output partition all of DEPTH. A boundary of DEPTH-1 gives the input partition the whole buffer. A zero-sized partition reads as both full and empty. The boundary resets to 63.
- R2: Host writes (`h_wr`, tag `h_wcmd`, 1 = command) leave the input queue in order. The CPU takes data bytes through register 0 and command bytes through register 1. `in_head_cmd` shows the head byte's tag, including in freeze mode.
- R3: A CPU read of register 0 while the head is a command byte, or of register 1 while the head is a data byte, returns 0xFF and does not advance the queue. A read of either register on an empty input queue also returns 0xFF.
- R4: `in_srq_n` is 0 while the input queue holds at least one byte and 1 while it is empty.
- R5: CPU writes to register 2 (data) or register 3 (command) fill the output queue. The host sees the head on `h_rdata`/`h_rcmd`, and `h_rd` pops it. `out_srq_n` is 0 while the output queue has room. A CPU write to a full output queue is dropped.
- R6: Outside freeze mode, a host write to a full input queue is dropped and sets the sticky `ovf_err`. A host read of an empty output queue sets the sticky `unf_err`.
- R7: Any write of the boundary register clears all four pointers to the start of their partitions and leaves both queues empty.
- R8: While freeze is on (CPU register 9, bit 0), host queue writes and reads are ignored and raise no error flag. The service flags then move only through CPU accesses.
- R9: The pointer registers (4 = input read, 5 = input write, 6 = output read, 7 = output write) can be read at any time. They load only in freeze mode, and a value not below the partition size is ignored.
- R10: When the pointers are equal, the queue is full if the pointer changed last was the write pointer and empty if it was the read pointer. A pointer load that does not change the value leaves the full/empty state unchanged.
- R11: A host push and a CPU pop of the same input queue in one cycle both take effect. A push into a full queue is still dropped even when a pop happens in the same cycle.
- R12: In normal mode a host immediate write loads the immediate-in register (CPU register 10) and sets `h_imm_busy`, and a CPU read of register 10 clears that flag. A CPU write of register 11 sets `h_imm_avail`, and a host immediate read clears it. In freeze mode a host immediate write does not load the register and clears `h_imm_busy`. A host immediate read in freeze mode returns 0 and clears `h_imm_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host push into input queue |
| h_wcmd | input | 1 | Tag of pushed byte, 1 = command |
| h_wdata | input | DW | Byte pushed by host |
| h_rd | input | 1 | Host pop from output queue |
| h_rdata | output | DW | Output queue head byte (0 when empty) |
| h_rcmd | output | 1 | Output queue head tag |
| h_imm_wr | input | 1 | Host write of immediate-in register |
| h_imm_wdata | input | DW | Immediate-in write data |
| h_imm_rd | input | 1 | Host read of immediate-out register |
| h_imm_rdata | output | DW | Immediate-out data (0 in freeze) |
| h_imm_busy | output | 1 | Immediate-in holds an unread byte |
| h_imm_avail | output | 1 | Immediate-out holds a fresh byte |
| c_we | input | 1 | CPU register write strobe |
| c_re | input | 1 | CPU register read strobe |
| c_addr | input | 4 | CPU register select |
| c_wdata | input | DW | CPU write data |
| c_rdata | output | DW | CPU read data |
| in_srq_n | output | 1 | Input service request, active low |
| out_srq_n | output | 1 | Output service request, active low |
| in_head_cmd | output | 1 | Input head byte is a command |
| ovf_err | output | 1 | Sticky input overflow |
| unf_err | output | 1 | Sticky output underflow |

## Verification
A host push and a CPU pop of the input queue can land in the same clock edge. The bench provokes this by raising `h_wr` and a read of register 0 together, on an empty queue, on a partly filled queue and on a full queue. The result is judged from the byte returned in that cycle, from the bytes that follow it and from the point where `in_srq_n` returns high. On a full queue the bench also expects `ovf_err` to be set, because the push was dropped.

// File: rtl/tf_pkg.sv
package tf_pkg;
   typedef enum logic [3:0] {
      RA_IN_DATA  = 4'd0,
      RA_IN_CMD   = 4'd1,
      RA_OUT_DATA = 4'd2,
      RA_OUT_CMD  = 4'd3,
      RA_IN_RP    = 4'd4,
      RA_IN_WP    = 4'd5,
      RA_OUT_RP   = 4'd6,
      RA_OUT_WP   = 4'd7,
      RA_BOUND    = 4'd8,
      RA_CTRL     = 4'd9,
      RA_IMM_IN   = 4'd10,
      RA_IMM_OUT  = 4'd11
   } reg_addr_e;
endpackage

// File: rtl/tf_ptr.sv
module tf_ptr #(
   parameter int AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          pop,
   input  logic          ld_r,
   input  logic          ld_w,
   input  logic [AW-1:0] ld_val,
   input  logic [AW:0]   size,
   output logic [AW-1:0] rp,
   output logic [AW-1:0] wp,
   output logic          empty,
   output logic          full
);
   logic lastw, zero, eq, do_push, do_pop, val_ok;

   function automatic logic [AW-1:0] step(input logic [AW-1:0] p, input logic [AW:0] sz);
      step = ({1'b0, p} == sz - 1'b1) ? '0 : p + 1'b1;
   endfunction

   assign zero    = (size == '0);
   assign eq      = (rp == wp);
   assign empty   = zero | (eq & ~lastw);
   assign full    = zero | (eq & lastw);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign val_ok  = ({1'b0, ld_val} < size);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp <= '0;
         wp <= '0;
         lastw <= 1'b0;
      end else if (clear) begin
         rp <= '0;
         wp <= '0;
         lastw <= 1'b0;
      end else if (ld_r | ld_w) begin
         if (ld_r && val_ok && ld_val != rp) begin
            rp <= ld_val;
            lastw <= 1'b0;
         end
         if (ld_w && val_ok && ld_val != wp) begin
            wp <= ld_val;
            lastw <= 1'b1;
         end
      end else begin
         if (do_push) wp <= step(wp, size);
         if (do_pop)  rp <= step(rp, size);
         if (do_push & ~do_pop)      lastw <= 1'b1;
         else if (do_pop & ~do_push) lastw <= 1'b0;
      end
   end
endmodule

// File: rtl/tf_imm.sv
module tf_imm #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frz,
   input  logic          h_wr,
   input  logic [DW-1:0] h_wdata,
   input  logic          h_rd,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] in_q,
   output logic          in_busy,
   output logic [DW-1:0] out_rdata,
   output logic          out_avail
);
   logic [DW-1:0] out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q <= '0;
         in_busy <= 1'b0;
         out_q <= '0;
         out_avail <= 1'b0;
      end else begin
         if (h_wr) begin
            if (frz) in_busy <= 1'b0;
            else begin
               in_q <= h_wdata;
               in_busy <= 1'b1;
            end
         end else if (cpu_rd) begin
            in_busy <= 1'b0;
         end
         if (cpu_wr) begin
            out_q <= cpu_wdata;
            out_avail <= 1'b1;
         end else if (h_rd) begin
            out_avail <= 1'b0;
         end
      end
   end

   assign out_rdata = frz ? '0 : out_q;
endmodule

// File: rtl/tf_part_fifo.sv
module tf_part_fifo #(
   parameter int DEPTH     = 128,
   parameter int DW        = 8,
   parameter int RST_BOUND = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          h_wr,
   input  logic          h_wcmd,
   input  logic [DW-1:0] h_wdata,
   input  logic          h_rd,
   output logic [DW-1:0] h_rdata,
   output logic          h_rcmd,
   input  logic          h_imm_wr,
   input  logic [DW-1:0] h_imm_wdata,
   input  logic          h_imm_rd,
   output logic [DW-1:0] h_imm_rdata,
   output logic          h_imm_busy,
   output logic          h_imm_avail,
   input  logic          c_we,
   input  logic          c_re,
   input  logic [3:0]    c_addr,
   input  logic [DW-1:0] c_wdata,
   output logic [DW-1:0] c_rdata,
   output logic          in_srq_n,
   output logic          out_srq_n,
   output logic          in_head_cmd,
   output logic          ovf_err,
   output logic          unf_err
);
   import tf_pkg::*;

   localparam int AW = $clog2(DEPTH);
   localparam int SW = AW + 1;
   localparam logic [AW-1:0] BND0 = AW'(RST_BOUND);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DW < AW) begin : g_bad_dw
      $error("DW must hold a pointer value");
   end
   if (RST_BOUND < 0 || RST_BOUND >= DEPTH) begin : g_bad_bound
      $error("RST_BOUND out of range");
   end

   logic [AW-1:0] bnd;
   logic          frz;
   logic [SW-1:0] in_size, out_size;
   logic [1:0]    push, pop, ld_r, ld_w, emp, ful;
   logic [1:0][AW-1:0] rp, wp;
   logic [1:0][SW-1:0] sz;
   logic [DW:0]   mem [DEPTH];
   logic [DW:0]   in_ent, out_ent;
   logic [AW-1:0] out_waddr, out_raddr;
   logic          cw_out_d, cw_out_c, cw_bnd, cw_ctrl, cw_immo;
   logic          cr_in_d, cr_in_c, cr_immi;
   logic [DW-1:0] imm_in_q;

   // register decode
   assign cw_out_d = c_we && c_addr == RA_OUT_DATA;
   assign cw_out_c = c_we && c_addr == RA_OUT_CMD;
   assign cw_bnd   = c_we && c_addr == RA_BOUND;
   assign cw_ctrl  = c_we && c_addr == RA_CTRL;
   assign cw_immo  = c_we && c_addr == RA_IMM_OUT;
   assign cr_in_d  = c_re && c_addr == RA_IN_DATA;
   assign cr_in_c  = c_re && c_addr == RA_IN_CMD;
   assign cr_immi  = c_re && c_addr == RA_IMM_IN;

   // partition sizes
   assign in_size  = (bnd == '0) ? '0 : {1'b0, bnd} + 1'b1;
   assign out_size = SW'(DEPTH) - in_size;
   assign sz[0] = in_size;
   assign sz[1] = out_size;

   assign in_ent    = mem[rp[0]];
   assign out_raddr = AW'(in_size + {1'b0, rp[1]});
   assign out_waddr = AW'(in_size + {1'b0, wp[1]});
   assign out_ent   = mem[out_raddr];

   // queue 0 = input (host fills), queue 1 = output (CPU fills)
   assign push[0] = h_wr & ~frz;
   assign pop[0]  = ~emp[0] & ((cr_in_d & ~in_ent[DW]) | (cr_in_c & in_ent[DW]));
   assign push[1] = cw_out_d | cw_out_c;
   assign pop[1]  = h_rd & ~frz;
   assign ld_r[0] = frz & c_we & (c_addr == RA_IN_RP);
   assign ld_w[0] = frz & c_we & (c_addr == RA_IN_WP);
   assign ld_r[1] = frz & c_we & (c_addr == RA_OUT_RP);
   assign ld_w[1] = frz & c_we & (c_addr == RA_OUT_WP);

   for (genvar g = 0; g < 2; g++) begin : g_q
      tf_ptr #(.AW(AW)) u_ptr (
         .clk    (clk),
         .rst_n  (rst_n),
         .clear  (cw_bnd),
         .push   (push[g]),
         .pop    (pop[g]),
         .ld_r   (ld_r[g]),
         .ld_w   (ld_w[g]),
         .ld_val (c_wdata[AW-1:0]),
         .size   (sz[g]),
         .rp     (rp[g]),
         .wp     (wp[g]),
         .empty  (emp[g]),
         .full   (ful[g])
      );
   end

   always_ff @(posedge clk) begin
      if (push[0] & ~ful[0]) mem[wp[0]] <= {h_wcmd, h_wdata};
      if (push[1] & ~ful[1]) mem[out_waddr] <= {cw_out_c, c_wdata};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd <= BND0;
         frz <= 1'b0;
         ovf_err <= 1'b0;
         unf_err <= 1'b0;
      end else begin
         if (cw_bnd)  bnd <= c_wdata[AW-1:0];
         if (cw_ctrl) frz <= c_wdata[0];
         if (h_wr & ~frz & ful[0]) ovf_err <= 1'b1;
         if (h_rd & ~frz & emp[1]) unf_err <= 1'b1;
      end
   end

   tf_imm #(.DW(DW)) u_imm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frz       (frz),
      .h_wr      (h_imm_wr),
      .h_wdata   (h_imm_wdata),
      .h_rd      (h_imm_rd),
      .cpu_rd    (cr_immi),
      .cpu_wr    (cw_immo),
      .cpu_wdata (c_wdata),
      .in_q      (imm_in_q),
      .in_busy   (h_imm_busy),
      .out_rdata (h_imm_rdata),
      .out_avail (h_imm_avail)
   );

   always_comb begin
      case (c_addr)
         RA_IN_DATA: c_rdata = (emp[0] | in_ent[DW])  ? {DW{1'b1}} : in_ent[DW-1:0];
         RA_IN_CMD:  c_rdata = (emp[0] | ~in_ent[DW]) ? {DW{1'b1}} : in_ent[DW-1:0];
         RA_IN_RP:   c_rdata = DW'(rp[0]);
         RA_IN_WP:   c_rdata = DW'(wp[0]);
         RA_OUT_RP:  c_rdata = DW'(rp[1]);
         RA_OUT_WP:  c_rdata = DW'(wp[1]);
         RA_BOUND:   c_rdata = DW'(bnd);
         RA_CTRL:    c_rdata = DW'(frz);
         RA_IMM_IN:  c_rdata = imm_in_q;
         default:    c_rdata = '0;
      endcase
   end

   assign h_rdata     = emp[1] ? '0 : out_ent[DW-1:0];
   assign h_rcmd      = ~emp[1] & out_ent[DW];
   assign in_head_cmd = ~emp[0] & in_ent[DW];
   assign in_srq_n    = emp[0];
   assign out_srq_n   = ful[1];
endmodule

// File: rtl/tf_part_fifo_chk.sv
module tf_part_fifo_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          frz,
   input logic          in_full,
   input logic          h_wr,
   input logic          h_imm_wr,
   input logic          c_we,
   input logic          c_re,
   input logic [3:0]    c_addr,
   input logic [DW-1:0] c_rdata,
   input logic          in_head_cmd,
   input logic          in_srq_n,
   input logic          ovf_err,
   input logic          h_imm_busy
);
   import tf_pkg::*;

   // R3
   wrong_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_re && c_addr == RA_IN_DATA && in_head_cmd) |-> c_rdata == {DW{1'b1}});

   // R6
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (h_wr && !frz && in_full) |=> ovf_err);

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> ovf_err);

   // R7
   bound_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_we && c_addr == RA_BOUND) |=> in_srq_n);

   // R8
   frz_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && h_wr && !c_we && !c_re) |=> $stable(in_srq_n));

   // R12
   imm_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz && h_imm_wr) |=> !h_imm_busy);
endmodule

bind tf_part_fifo tf_part_fifo_chk #(.DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frz         (frz),
   .in_full     (ful[0]),
   .h_wr        (h_wr),
   .h_imm_wr    (h_imm_wr),
   .c_we        (c_we),
   .c_re        (c_re),
   .c_addr      (c_addr),
   .c_rdata     (c_rdata),
   .in_head_cmd (in_head_cmd),
   .in_srq_n    (in_srq_n),
   .ovf_err     (ovf_err),
   .h_imm_busy  (h_imm_busy)
);

// File: tb/tf_part_fifo_test.sv
`timescale 1ns/1ps
module tf_part_fifo_test;
   logic clk = 1'b0;
   logic rst_n;
   logic h_wr, h_wcmd, h_rd, h_imm_wr, h_imm_rd, c_we, c_re;
   logic [7:0] h_wdata, h_imm_wdata, c_wdata;
   logic [3:0] c_addr;
   logic [7:0] h_rdata, h_imm_rdata, c_rdata;
   logic h_rcmd, h_imm_busy, h_imm_avail, in_srq_n, out_srq_n, in_head_cmd, ovf_err, unf_err;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   tf_part_fifo uut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {h_wr, h_wcmd, h_rd, h_imm_wr, h_imm_rd, c_we, c_re} = '0;
      h_wdata = '0; h_imm_wdata = '0; c_wdata = '0; c_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cpu_wr(input logic [3:0] a, input logic [7:0] d);
      c_we = 1'b1; c_addr = a; c_wdata = d;
      @(negedge clk);
      c_we = 1'b0;
      #1;
   endtask

   task automatic cpu_rd(input logic [3:0] a, output logic [7:0] d);
      c_re = 1'b1; c_addr = a;
      #1 d = c_rdata;
      @(negedge clk);
      c_re = 1'b0;
      #1;
   endtask

   task automatic host_wr(input logic [7:0] d, input logic cmd);
      h_wr = 1'b1; h_wdata = d; h_wcmd = cmd;
      @(negedge clk);
      h_wr = 1'b0;
      #1;
   endtask

   task automatic host_rd(output logic [7:0] d, output logic cmd);
      h_rd = 1'b1;
      #1 begin d = h_rdata; cmd = h_rcmd; end
      @(negedge clk);
      h_rd = 1'b0;
      #1;
   endtask

   task automatic both_op(input logic [7:0] hd, output logic [7:0] got);
      h_wr = 1'b1; h_wdata = hd; h_wcmd = 1'b0; c_re = 1'b1; c_addr = 4'd0;
      #1 got = c_rdata;
      @(negedge clk);
      h_wr = 1'b0; c_re = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      do_reset();
      #1;
      chk("R4 reset in_srq_n", in_srq_n, 1);
      chk("R5 reset out_srq_n", out_srq_n, 0);
      chk("R6 reset errors", {ovf_err, unf_err}, 0);
      chk("R12 reset imm flags", {h_imm_busy, h_imm_avail}, 0);
      cpu_rd(4'd8, d);
      chk("R1 reset boundary", d, 8'd63);
   endtask

   task automatic t_tags();
      logic [7:0] d;
      do_reset();
      host_wr(8'h11, 1'b0);
      host_wr(8'hA5, 1'b1);
      host_wr(8'h22, 1'b0);
      chk("R4 in_srq_n low with bytes", in_srq_n, 0);
      chk("R2 head tag data", in_head_cmd, 0);
      cpu_rd(4'd1, d);
      chk("R3 cmd read on data head", d, 8'hFF);
      cpu_rd(4'd0, d);
      chk("R2 first data byte", d, 8'h11);
      chk("R2 head tag command", in_head_cmd, 1);
      cpu_rd(4'd0, d);
      chk("R3 data read on cmd head", d, 8'hFF);
      cpu_rd(4'd1, d);
      chk("R2 command byte", d, 8'hA5);
      cpu_rd(4'd0, d);
      chk("R2 last data byte", d, 8'h22);
      chk("R4 in_srq_n high when drained", in_srq_n, 1);
      cpu_rd(4'd0, d);
      chk("R3 empty read", d, 8'hFF);
   endtask

   task automatic t_out();
      logic [7:0] d;
      logic c;
      do_reset();
      cpu_wr(4'd2, 8'h33);
      cpu_wr(4'd3, 8'h44);
      host_rd(d, c);
      chk("R5 out data byte", {c, d}, {1'b0, 8'h33});
      host_rd(d, c);
      chk("R5 out cmd byte", {c, d}, {1'b1, 8'h44});
      chk("R6 no underflow yet", unf_err, 0);
      host_rd(d, c);
      chk("R6 underflow sticky", unf_err, 1);
   endtask

   task automatic t_bounds();
      logic [7:0] d;
      logic c;
      do_reset();
      cpu_wr(4'd8, 8'h7F);
      chk("R1 output size zero reads full", out_srq_n, 1);
      for (int i = 0; i < 128; i++) host_wr(8'(i), 1'b0);
      chk("R6 no overflow at exactly full", ovf_err, 0);
      host_wr(8'hEE, 1'b0);
      chk("R6 overflow on full input", ovf_err, 1);
      for (int i = 0; i < 128; i++) begin
         cpu_rd(4'd0, d);
         chk("R1 whole-buffer input order", d, 8'(i));
      end
      chk("R1 input drained", in_srq_n, 1);
      host_wr(8'h01, 1'b0);
      cpu_wr(4'd8, 8'h00);
      chk("R7 boundary write empties input", in_srq_n, 1);
      for (int i = 0; i < 128; i++) cpu_wr(4'd2, 8'(i) ^ 8'h5A);
      chk("R1 output holds 128", out_srq_n, 1);
      cpu_wr(4'd2, 8'h00);
      for (int i = 0; i < 128; i++) begin
         host_rd(d, c);
         chk("R5 whole-buffer output order", d, 8'(i) ^ 8'h5A);
      end
      chk("R5 output has room again", out_srq_n, 0);
      chk("R6 no underflow on exact drain", unf_err, 0);
   endtask

   task automatic t_simul();
      logic [7:0] d;
      do_reset();
      cpu_wr(4'd8, 8'd3);
      host_wr(8'h21, 1'b0);
      both_op(8'h22, d);
      chk("R11 pop returns old head", d, 8'h21);
      cpu_rd(4'd0, d);
      chk("R11 push landed", d, 8'h22);
      chk("R11 empty after", in_srq_n, 1);
      both_op(8'h23, d);
      chk("R11 pop on empty returns FF", d, 8'hFF);
      cpu_rd(4'd0, d);
      chk("R11 push on empty landed", d, 8'h23);
      for (int i = 0; i < 4; i++) host_wr(8'h40 + 8'(i), 1'b0);
      both_op(8'h55, d);
      chk("R11 pop on full", d, 8'h40);
      chk("R11 push into full dropped sets ovf", ovf_err, 1);
      for (int i = 1; i < 4; i++) begin
         cpu_rd(4'd0, d);
         chk("R11 remaining bytes", d, 8'h40 + 8'(i));
      end
      chk("R11 no extra byte", in_srq_n, 1);
   endtask

   task automatic t_freeze();
      logic [7:0] d;
      logic c;
      do_reset();
      cpu_wr(4'd8, 8'd3);
      host_wr(8'h10, 1'b0);
      host_wr(8'h81, 1'b1);
      host_wr(8'h12, 1'b0);
      host_wr(8'h13, 1'b0);
      cpu_rd(4'd0, d);
      cpu_rd(4'd1, d);
      cpu_rd(4'd0, d);
      cpu_rd(4'd0, d);
      chk("R2 drained before freeze", {in_srq_n, d}, {1'b1, 8'h13});
      cpu_wr(4'd5, 8'd2);
      cpu_rd(4'd5, d);
      chk("R9 load ignored outside freeze", d, 0);
      cpu_wr(4'd9, 8'd1);
      host_wr(8'h99, 1'b0);
      cpu_rd(4'd5, d);
      chk("R8 host write ignored in freeze", {in_srq_n, ovf_err, d}, {1'b1, 1'b0, 8'd0});
      host_rd(d, c);
      chk("R8 host read ignored in freeze", unf_err, 0);
      cpu_wr(4'd4, 8'd0);
      cpu_wr(4'd5, 8'd0);
      chk("R10 unchanged zero loads stay empty", in_srq_n, 1);
      cpu_wr(4'd5, 8'd1);
      chk("R10 nonzero write pointer", in_srq_n, 0);
      cpu_wr(4'd5, 8'd0);
      chk("R10 write pointer last gives full", in_srq_n, 0);
      cpu_rd(4'd0, d);
      chk("R10 full read byte 0", d, 8'h10);
      chk("R2 tag flag valid in freeze", in_head_cmd, 1);
      cpu_rd(4'd1, d);
      chk("R10 full read byte 1", d, 8'h81);
      cpu_rd(4'd0, d);
      cpu_rd(4'd0, d);
      chk("R10 full read byte 3", {in_srq_n, d}, {1'b1, 8'h13});
      cpu_wr(4'd5, 8'd2);
      cpu_wr(4'd4, 8'd2);
      chk("R10 read pointer last gives empty", in_srq_n, 1);
      cpu_wr(4'd5, 8'd9);
      cpu_rd(4'd5, d);
      chk("R9 out-of-range load ignored", d, 8'd2);
      cpu_wr(4'd9, 8'd0);
      cpu_wr(4'd5, 8'd3);
      cpu_rd(4'd5, d);
      chk("R9 load ignored after freeze", d, 8'd2);
   endtask

   task automatic t_imm();
      logic [7:0] d;
      do_reset();
      h_imm_wr = 1'b1; h_imm_wdata = 8'h5A;
      @(negedge clk); h_imm_wr = 1'b0; #1;
      chk("R12 busy after host write", h_imm_busy, 1);
      cpu_wr(4'd9, 8'd1);
      h_imm_wr = 1'b1; h_imm_wdata = 8'h77;
      @(negedge clk); h_imm_wr = 1'b0; #1;
      chk("R12 freeze write clears busy", h_imm_busy, 0);
      cpu_rd(4'd10, d);
      chk("R12 freeze write not loaded", d, 8'h5A);
      cpu_wr(4'd9, 8'd0);
      cpu_wr(4'd11, 8'h3C);
      chk("R12 avail after CPU write", h_imm_avail, 1);
      h_imm_rd = 1'b1;
      #1 d = h_imm_rdata;
      @(negedge clk); h_imm_rd = 1'b0; #1;
      chk("R12 normal host read", {h_imm_avail, d}, {1'b0, 8'h3C});
      cpu_wr(4'd11, 8'h3D);
      cpu_wr(4'd9, 8'd1);
      h_imm_rd = 1'b1;
      #1 d = h_imm_rdata;
      @(negedge clk); h_imm_rd = 1'b0; #1;
      chk("R12 freeze host read", {h_imm_avail, d}, {1'b0, 8'h00});
      h_imm_wr = 1'b1; h_imm_wdata = 8'h01;
      @(negedge clk); h_imm_wr = 1'b0; #1;
      cpu_wr(4'd9, 8'd0);
      h_imm_wr = 1'b1; h_imm_wdata = 8'h66;
      @(negedge clk); h_imm_wr = 1'b0; #1;
      cpu_rd(4'd10, d);
      chk("R12 CPU read clears busy", {h_imm_busy, d}, {1'b0, 8'h66});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_tags();
      t_out();
      t_bounds();
      t_simul();
      t_freeze();
      t_imm();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule